// File: doc/BRIEF.md
# Register-Mapped Serial Port with Programmable Bit Period

This block is an asynchronous serial transmitter and receiver that a processor reaches through two 32-bit words. The first word holds the bit period, counted in system clocks. The second word is the data port: a write sends one byte on the TX line, and a read hands back the byte that arrived last on the RX line. Frames carry one start bit, eight data bits sent least significant bit first, and one stop bit. There is no parity.

The receiver keeps exactly one byte. A read of the data word takes that byte out of the buffer. If no byte is waiting, the read returns a word with every bit set. A write to the data word while a frame is still going out is held off through a wait signal and is accepted as soon as the transmitter is free. The two words sit at consecutive word offsets. The bus decoder passes the word index to the block on a one-bit select, which it normally takes from byte address bit 2.

Top module: `bus_uart`

## Requirements
- R1: After reset the TX line is high, the receive buffer is empty, and the divider word reads back the parameter DIV_RESET.
- R2: bus_sel = 0 addresses the divider word. A write stores bits [DIV_W-1:0] of bus_wdata, and a read returns that value zero-extended to 32 bits. bus_sel = 1 addresses the data word.
- R3: A data read while a byte is buffered returns the byte zero-extended to 32 bits and empties the buffer, so the next read returns 32'hFFFF_FFFF.
- R4: A data read with the buffer empty returns 32'hFFFF_FFFF.
- R5: An accepted data write sends bus_wdata[7:0]. The start bit (0) appears in the cycle after the accepting clock edge. Eight data bits follow, LSB first, then a stop bit (1). Each bit lasts exactly divider clocks. TX is high whenever no frame is in progress.
- R6: While a frame is in progress, bus_wait is high during a data write and no new frame starts. The write is accepted in the first cycle the transmitter is idle, and the next frame follows the previous one with no gap.
- R7: The receiver synchronises RX through two flops and starts on a high-to-low transition. It samples half a divider period after detection and then once per divider period, assembling bits LSB first.
- R8: A newly received byte replaces an unread buffered byte.
- R9: A low pulse on RX that has ended by the half-period sample is a false start and leaves the buffer unchanged.
- R10: A frame whose stop sample is low is discarded. The receiver then waits for RX to go high again and fall before it accepts another frame.
- R11: A new divider value sets the bit period of every later frame in both directions, odd values included.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid | input | 1 | Bus access request |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_sel | input | 1 | Word select: 0 divider, 1 data |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data |
| bus_wait | output | 1 | Stall for a data write while transmitting |
| uart_tx | output | 1 | Serial output line |
| uart_rx | input | 1 | Serial input line |

## Verification
The bench builds the block with DIV_W = 16 and DIV_RESET = 12. The small reset divider means frames can be sent before any divider write, and the bench then reprograms the period to 8 and to the odd value 5. With DIV_W = 16, a divider write whose upper bus bits are nonzero shows whether truncation works. A period of 8 is long enough for a two-cycle RX glitch to end before the half-period sample. The same period lets the bench check the false-start path and the framing-error path separately from normal reception.

// File: rtl/bus_uart_pkg.sv
package bus_uart_pkg;
    localparam int WORD_W     = 32;
    localparam int DATA_BITS  = 8;
    localparam int FRAME_BITS = DATA_BITS + 2;
    localparam int CNT_BITS_W = $clog2(FRAME_BITS + 1);

    typedef enum logic [1:0] {
        RX_IDLE  = 2'd0,
        RX_START = 2'd1,
        RX_DATA  = 2'd2,
        RX_STOP  = 2'd3
    } rx_phase_e;
endpackage

// File: rtl/bus_uart_tx.sv
module bus_uart_tx
    import bus_uart_pkg::*;
#(
    parameter int DIV_W = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic [DATA_BITS-1:0] data,
    input  logic [DIV_W-1:0]     div,
    output logic                 txd,
    output logic                 busy
);
    typedef struct packed {
        logic [FRAME_BITS-1:0] shift;
        logic [CNT_BITS_W-1:0] left;
        logic [DIV_W-1:0]      cnt;
    } tx_state_t;

    tx_state_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (s_q.left == '0) begin
            if (start) begin
                s_d.shift = {1'b1, data, 1'b0};
                s_d.left  = CNT_BITS_W'(FRAME_BITS);
                s_d.cnt   = div - 1'b1;
            end
        end else if (s_q.cnt == '0) begin
            s_d.shift = {1'b1, s_q.shift[FRAME_BITS-1:1]};
            s_d.left  = s_q.left - 1'b1;
            s_d.cnt   = div - 1'b1;
        end else begin
            s_d.cnt = s_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '{shift: '1, left: '0, cnt: '0};
        end else begin
            s_q <= s_d;
        end
    end

    assign busy = (s_q.left != '0);
    assign txd  = busy ? s_q.shift[0] : 1'b1;
endmodule

// File: rtl/bus_uart_rx.sv
module bus_uart_rx
    import bus_uart_pkg::*;
#(
    parameter int DIV_W = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 rxd,
    input  logic [DIV_W-1:0]     div,
    output logic                 done,
    output logic [DATA_BITS-1:0] byte_out
);
    typedef struct packed {
        logic [1:0]            sync;
        logic                  prev;
        rx_phase_e             phase;
        logic [DIV_W-1:0]      cnt;
        logic [2:0]            nbits;
        logic [DATA_BITS-1:0]  shift;
        logic                  done;
        logic [DATA_BITS-1:0]  data;
    } rx_state_t;

    rx_state_t s_d, s_q;
    logic      line;

    assign line = s_q.sync[1];

    always_comb begin
        s_d      = s_q;
        s_d.sync = {s_q.sync[0], rxd};
        s_d.prev = line;
        s_d.done = 1'b0;
        unique case (s_q.phase)
            RX_IDLE: begin
                if (s_q.prev && !line) begin
                    s_d.phase = RX_START;
                    s_d.cnt   = (div >> 1) - 1'b1;
                end
            end
            RX_START: begin
                if (s_q.cnt == '0) begin
                    if (!line) begin
                        s_d.phase = RX_DATA;
                        s_d.cnt   = div - 1'b1;
                        s_d.nbits = '0;
                    end else begin
                        s_d.phase = RX_IDLE;
                    end
                end else begin
                    s_d.cnt = s_q.cnt - 1'b1;
                end
            end
            RX_DATA: begin
                if (s_q.cnt == '0) begin
                    s_d.shift = {line, s_q.shift[DATA_BITS-1:1]};
                    s_d.nbits = s_q.nbits + 1'b1;
                    s_d.cnt   = div - 1'b1;
                    if (s_q.nbits == 3'd7) begin
                        s_d.phase = RX_STOP;
                    end
                end else begin
                    s_d.cnt = s_q.cnt - 1'b1;
                end
            end
            RX_STOP: begin
                if (s_q.cnt == '0) begin
                    if (line) begin
                        s_d.done = 1'b1;
                        s_d.data = s_q.shift;
                    end
                    s_d.phase = RX_IDLE;
                end else begin
                    s_d.cnt = s_q.cnt - 1'b1;
                end
            end
            default: s_d.phase = RX_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '{sync: 2'b11, prev: 1'b1, phase: RX_IDLE, cnt: '0,
                     nbits: '0, shift: '0, done: 1'b0, data: '0};
        end else begin
            s_q <= s_d;
        end
    end

    assign done     = s_q.done;
    assign byte_out = s_q.data;
endmodule

// File: rtl/bus_uart.sv
module bus_uart
    import bus_uart_pkg::*;
#(
    parameter int DIV_W     = 16,
    parameter int DIV_RESET = 868
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_valid,
    input  logic              bus_we,
    input  logic              bus_sel,
    input  logic [WORD_W-1:0] bus_wdata,
    output logic [WORD_W-1:0] bus_rdata,
    output logic              bus_wait,
    output logic              uart_tx,
    input  logic              uart_rx
);
    typedef struct packed {
        logic [DIV_W-1:0]     div;
        logic [DATA_BITS-1:0] rx_byte;
        logic                 rx_full;
    } reg_state_t;

    reg_state_t           r_d, r_q;
    logic                 tx_busy;
    logic                 tx_start;
    logic                 rx_done;
    logic [DATA_BITS-1:0] rx_data;
    logic                 rd_data, wr_data, wr_div;
    logic [WORD_W-1:0]    div_word;
    logic                 unused_wbits;

    assign unused_wbits = ^bus_wdata;

    assign rd_data  = bus_valid && !bus_we && bus_sel;
    assign wr_data  = bus_valid && bus_we && bus_sel;
    assign wr_div   = bus_valid && bus_we && !bus_sel;
    assign bus_wait = wr_data && tx_busy;
    assign tx_start = wr_data && !tx_busy;

    always_comb begin
        r_d = r_q;
        if (wr_div) begin
            r_d.div = bus_wdata[DIV_W-1:0];
        end
        if (rd_data) begin
            r_d.rx_full = 1'b0;
        end
        if (rx_done) begin
            r_d.rx_byte = rx_data;
            r_d.rx_full = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '{div: DIV_W'(DIV_RESET), rx_byte: '0, rx_full: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        div_word              = '0;
        div_word[DIV_W-1:0]   = r_q.div;
        if (!bus_sel) begin
            bus_rdata = div_word;
        end else if (r_q.rx_full) begin
            bus_rdata = {{(WORD_W-DATA_BITS){1'b0}}, r_q.rx_byte};
        end else begin
            bus_rdata = '1;
        end
    end

    bus_uart_tx #(.DIV_W(DIV_W)) u_tx (
        .clk   (clk),
        .rst_n (rst_n),
        .start (tx_start),
        .data  (bus_wdata[DATA_BITS-1:0]),
        .div   (r_q.div),
        .txd   (uart_tx),
        .busy  (tx_busy)
    );

    bus_uart_rx #(.DIV_W(DIV_W)) u_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .rxd      (uart_rx),
        .div      (r_q.div),
        .done     (rx_done),
        .byte_out (rx_data)
    );
endmodule

// File: rtl/bus_uart_checker.sv
module bus_uart_checker (
    input logic clk,
    input logic rst_n,
    input logic bus_valid,
    input logic bus_we,
    input logic bus_sel,
    input logic bus_wait,
    input logic uart_tx,
    input logic tx_busy,
    input logic rx_done,
    input logic rx_full
);
    a_r5_start_bit_follows_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && bus_we && bus_sel && !bus_wait) |=> (!uart_tx && tx_busy));

    a_r5_line_idles_high: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_busy |-> uart_tx);

    a_r5_stop_bit_high: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(tx_busy) |-> $past(uart_tx));

    a_r3_read_empties: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && !bus_we && bus_sel && !rx_done) |=> !rx_full);

    a_r7_byte_buffered: assert property (@(posedge clk) disable iff (!rst_n)
        rx_done |=> rx_full);
endmodule

bind bus_uart bus_uart_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_valid (bus_valid),
    .bus_we    (bus_we),
    .bus_sel   (bus_sel),
    .bus_wait  (bus_wait),
    .uart_tx   (uart_tx),
    .tx_busy   (tx_busy),
    .rx_done   (rx_done),
    .rx_full   (r_q.rx_full)
);

// File: tb/bus_uart_bench.sv
`timescale 1ns/1ps
module bus_uart_bench;
    localparam int DIV_W     = 16;
    localparam int DIV_RESET = 12;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_valid = 1'b0;
    logic        bus_we = 1'b0;
    logic        bus_sel = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_wait;
    logic        uart_tx;
    logic        uart_rx = 1'b1;

    int checks = 0;
    int fails  = 0;
    int cur_div = DIV_RESET;
    bit done_flag = 0;
    bit tx_q[$];

    always #5 clk = ~clk;

    bus_uart #(.DIV_W(DIV_W), .DIV_RESET(DIV_RESET)) u_bus_uart (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_valid (bus_valid),
        .bus_we    (bus_we),
        .bus_sel   (bus_sel),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .bus_wait  (bus_wait),
        .uart_tx   (uart_tx),
        .uart_rx   (uart_rx)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    // Reference transmit model: one expected line value per clock.
    always @(posedge clk) begin
        if (!rst_n) begin
            tx_q.delete();
        end else begin
            if (tx_q.size() != 0) void'(tx_q.pop_front());
            if (bus_valid && bus_we && bus_sel && !bus_wait) begin
                for (int b = 0; b < 10; b++) begin
                    bit v;
                    v = (b == 0) ? 1'b0 : (b == 9) ? 1'b1 : bus_wdata[b-1];
                    for (int k = 0; k < cur_div; k++) tx_q.push_back(v);
                end
            end
        end
    end

    // Per-clock comparison of TX line (R5) and stall signal (R6).
    always begin
        @(negedge clk);
        #1;
        if (rst_n) begin
            check("R5 tx line", {31'b0, uart_tx}, {31'b0, (tx_q.size() != 0) ? tx_q[0] : 1'b1});
            check("R6 bus_wait", {31'b0, bus_wait},
                  {31'b0, bus_valid && bus_we && bus_sel && (tx_q.size() != 0)});
        end
    end

    task automatic bus_write(input logic sel, input logic [31:0] data);
        bus_valid = 1'b1; bus_we = 1'b1; bus_sel = sel; bus_wdata = data;
        #1;
        while (bus_wait) begin
            @(negedge clk);
            #1;
        end
        @(negedge clk);
        bus_valid = 1'b0; bus_we = 1'b0;
    endtask

    task automatic bus_read(input logic sel, input logic [31:0] exp, input string tag);
        bus_valid = 1'b1; bus_we = 1'b0; bus_sel = sel;
        #1;
        check(tag, bus_rdata, exp);
        @(negedge clk);
        bus_valid = 1'b0;
    endtask

    task automatic set_div(input logic [31:0] word);
        bus_write(1'b0, word);
        cur_div = int'(word[DIV_W-1:0]);
    endtask

    task automatic wait_tx_idle();
        while (tx_q.size() != 0) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    task automatic send_rx(input logic [7:0] data, input logic stop_bit);
        for (int b = 0; b < 10; b++) begin
            uart_rx = (b == 0) ? 1'b0 : (b == 9) ? stop_bit : data[b-1];
            repeat (cur_div) @(negedge clk);
        end
        uart_rx = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done_flag) begin
            fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        bus_read(1'b0, 32'(DIV_RESET), "R1 divider reset value");
        bus_read(1'b1, 32'hFFFF_FFFF, "R1 R4 empty after reset");
        check("R1 tx idle", {31'b0, uart_tx}, 32'd1);

        // R5: frame at the reset divider
        bus_write(1'b1, 32'h0000_00A5);
        wait_tx_idle();

        // R6: back-to-back writes stall then follow without gap
        bus_write(1'b1, 32'h1234_563C);
        bus_write(1'b1, 32'h0000_00C3);
        wait_tx_idle();

        // R2: divider truncation and readback
        set_div(32'hABCD_0008);
        bus_read(1'b0, 32'h0000_0008, "R2 divider readback truncated");

        // R11: transmit at new period
        bus_write(1'b1, 32'h0000_0081);
        wait_tx_idle();

        // R7 R3: receive one byte, read consumes
        send_rx(8'h5A, 1'b1);
        bus_read(1'b1, 32'h0000_005A, "R7 R3 received byte");
        bus_read(1'b1, 32'hFFFF_FFFF, "R3 buffer emptied by read");

        // R8: overwrite
        send_rx(8'h11, 1'b1);
        send_rx(8'hEE, 1'b1);
        bus_read(1'b1, 32'h0000_00EE, "R8 newest byte kept");

        // R9: false start glitch
        uart_rx = 1'b0;
        repeat (2) @(negedge clk);
        uart_rx = 1'b1;
        repeat (3 * cur_div) @(negedge clk);
        bus_read(1'b1, 32'hFFFF_FFFF, "R9 glitch ignored");

        // R10: framing error then recovery
        send_rx(8'h77, 1'b0);
        bus_read(1'b1, 32'hFFFF_FFFF, "R10 bad stop discarded");
        send_rx(8'h42, 1'b1);
        bus_read(1'b1, 32'h0000_0042, "R10 next frame accepted");

        // R11: odd divider both directions
        set_div(32'h0000_0005);
        bus_read(1'b0, 32'h0000_0005, "R11 R2 odd divider readback");
        bus_write(1'b1, 32'h0000_0096);
        bus_write(1'b1, 32'h0000_0069);
        wait_tx_idle();
        send_rx(8'h96, 1'b1);
        bus_read(1'b1, 32'h0000_0096, "R11 receive at odd period");
        bus_read(1'b1, 32'hFFFF_FFFF, "R4 empty again");

        done_flag = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule